// File: doc/BRIEF.md
# Adaptive Green-Time Decision Unit

This unit decides the cycle in which the current green phase at a two-arm intersection should end. It keeps a running count of queued cars for each arm from entry and exit sensor pulses. It keeps a time-in-phase clock that advances on a slow tick enable. For each arm it evaluates a weighted queue comparison. From these it raises a one-cycle switch request towards the phase sequencer, which then moves the lamps on.

The sequencer tells the unit which arm is currently favoured and which phase is running. The phase is one of: main green, protected left turn, pedestrian crossing, or hold. Software-loaded limits set the shortest and longest green for each arm, for the left-turn phase and for the pedestrian phase. For each arm the unit forms f = alpha·n_self + beta − n_other, and only the sign of f is used. Between the minimum and maximum times of a main green, the phase ends early when f is not positive, when the favoured queue is empty, or when that queue has not moved for five ticks.

Top module: `green_end_decider`

## Requirements
- R1: An entry pulse raises the arm's count by one and an exit pulse lowers it by one. Both pulses in the same cycle leave the count unchanged, and such a cycle does not count as a queue change for the stall rule.
- R2: Each count is held at 0 when an exit pulse arrives at 0, and held at 2047 (11-bit maximum) when an entry pulse arrives at 2047.
- R3: In main green between the favoured arm's minimum and maximum, a request is raised when f ≤ 0. Here f = alpha·n_self + beta − n_other, alpha is a 4-bit unsigned value, and beta is a 12-bit two's-complement value. The arithmetic is wide enough never to overflow.
- R4: In main green no request is raised while the time-in-phase is below the favoured arm's minimum. Arm code 0 selects the arm-0 limits, alpha and beta, and arm code 1 selects the arm-1 set.
- R5: In main green, a request is raised once the time-in-phase has reached both the favoured arm's maximum and its minimum.
- R6: In main green between minimum and maximum, a request is raised when the favoured arm's count is 0.
- R7: In main green between minimum and maximum, a request is raised once five ticks have passed without a change in the favoured arm's count. A change of that count, or a request, restarts this tick tally.
- R8: In the left-turn phase (code 1), no request is raised below the left minimum, and a request is raised at the left maximum. Between the two, only an empty favoured queue ends the phase; f and the stall rule do not apply.
- R9: In the pedestrian phase (code 2), a request is raised once the time-in-phase reaches the pedestrian limit, whatever the counts.
- R10: With phase code 3 (hold), no request is ever raised. Phase code 0 is main green.
- R11: A request is a registered pulse exactly one cycle long. It appears one cycle after the edge at which its condition first holds. The time-in-phase advances by one on each cycle with the tick high, and returns to 0 on the edge after a request, so a new decision starts from zero time.
- R12: Under synchronous active-low reset the request is low and the counts, the time-in-phase and the stall tally are all cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Time-base enable; phase time and stall tally advance only when high |
| car_enter | input | 2 | Per-arm entry sensor pulse, bit index = arm |
| car_leave | input | 2 | Per-arm exit sensor pulse, bit index = arm |
| arm_sel | input | 1 | Favoured arm (0 or 1) |
| phase | input | 2 | 0 main green, 1 left turn, 2 pedestrian, 3 hold |
| alpha_a0 | input | 4 | Queue weight for arm 0 |
| alpha_a1 | input | 4 | Queue weight for arm 1 |
| beta_a0 | input | 12 | Signed bias for arm 0 |
| beta_a1 | input | 12 | Signed bias for arm 1 |
| gmin_a0 | input | 8 | Minimum main green time, arm 0 |
| gmax_a0 | input | 8 | Maximum main green time, arm 0 |
| gmin_a1 | input | 8 | Minimum main green time, arm 1 |
| gmax_a1 | input | 8 | Maximum main green time, arm 1 |
| left_min | input | 8 | Minimum left-turn time |
| left_max | input | 8 | Maximum left-turn time |
| ped_max | input | 8 | Pedestrian phase duration |
| switch_req | output | 1 | One-cycle request to end the current phase |

## Verification
On every cycle, assertions check the following: a request is never raised before the favoured minimum, a request always follows the main, left or pedestrian maximum, hold stays quiet, every request is a single cycle, the phase clock clears after a request and stands still without a tick, and counts neither move on paired pulses nor cross 0 or 2047. Only the bench's scenarios can show the early-exit cases, because they depend on the count history: the sign of f with weighted and negative-bias operands, the empty-queue rule, the stall rule and its restart on a count change, and the count values reached after underflow and overflow attempts. Each scenario predicts the exact cycle of the request from these rules.

// File: rtl/gtd_pkg.sv
// Package: shared types and constants for the green-time decision unit.
// Assumes exactly two arms; phase codes are fixed by the sequencer.
package gtd_pkg;
    localparam int NUM_ARMS = 2;

    typedef enum logic [1:0] {
        PH_MAIN = 2'd0,
        PH_LEFT = 2'd1,
        PH_PED  = 2'd2,
        PH_HOLD = 2'd3
    } gtd_phase_e;
endpackage

// File: rtl/gtd_car_tally.sv
// Module: saturating up/down car counter for one arm.
// Assumes enter/leave are single-cycle sensor pulses already synchronised.
module gtd_car_tally #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enter,
    input  logic          leave,
    output logic [CW-1:0] cnt,
    output logic          moved
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic up, dn;

    // Purpose: decide a real step; paired pulses and saturated ends do nothing.
    assign up    = enter && !leave && (cnt != CMAX);
    assign dn    = leave && !enter && (cnt != '0);
    assign moved = up || dn;

    // Purpose: hold the queue count.
    always_ff @(posedge clk) begin
        if (!rst_n)  cnt <= '0;
        else if (up) cnt <= cnt + CW'(1);
        else if (dn) cnt <= cnt - CW'(1);
    end

    assert_pair_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (enter && leave) |=> (cnt == $past(cnt)));
    assert_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && leave && !enter) |=> (cnt == '0));
    assert_ceiling_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CMAX && enter && !leave) |=> (cnt == CMAX));
endmodule

// File: rtl/gtd_phase_clock.sv
// Module: time-in-phase counter and stall tally for the favoured queue.
// Assumes clear is the registered switch request; both counters saturate.
module gtd_phase_clock #(
    parameter int TW          = 8,
    parameter int STALL_TICKS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clear,
    input  logic          self_moved,
    output logic [TW-1:0] t_val,
    output logic          stalled
);
    localparam int SW = $clog2(STALL_TICKS + 1);
    localparam logic [SW-1:0] SLIM = SW'(STALL_TICKS);

    logic [SW-1:0] s_val;

    // Purpose: count ticks spent in the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                                t_val <= '0;
        else if (clear)                            t_val <= '0;
        else if (tick && (t_val != {TW{1'b1}}))    t_val <= t_val + TW'(1);
    end

    // Purpose: count ticks since the favoured queue last changed.
    always_ff @(posedge clk) begin
        if (!rst_n)                         s_val <= '0;
        else if (clear || self_moved)       s_val <= '0;
        else if (tick && (s_val != SLIM))   s_val <= s_val + SW'(1);
    end

    assign stalled = (s_val == SLIM);

    assert_clock_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (t_val == '0));
    assert_clock_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(t_val));
endmodule

// File: rtl/gtd_verdict.sv
// Module: evaluates the control function per arm and the phase rules,
// and registers the one-cycle switch request.
// Assumes counts, time and stall flag come from registers in the same clock.
module gtd_verdict
    import gtd_pkg::*;
#(
    parameter int CW = 11,
    parameter int TW = 8,
    parameter int AW = 4,
    parameter int BW = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  gtd_phase_e                       phase,
    input  logic                             arm_sel,
    input  logic [TW-1:0]                    t_val,
    input  logic                             stalled,
    input  logic [NUM_ARMS-1:0][CW-1:0]      n_arm,
    input  logic [NUM_ARMS-1:0][AW-1:0]      alpha,
    input  logic [NUM_ARMS-1:0][BW-1:0]      beta,
    input  logic [NUM_ARMS-1:0][TW-1:0]      gmin,
    input  logic [NUM_ARMS-1:0][TW-1:0]      gmax,
    input  logic [TW-1:0]                    left_min,
    input  logic [TW-1:0]                    left_max,
    input  logic [TW-1:0]                    ped_max,
    output logic                             sw_req
);
    localparam int FW = AW + CW + 2;

    logic [NUM_ARMS-1:0] f_nonpos;
    logic [TW-1:0]       min_sel, max_sel;
    logic                self_empty, want;

    // Purpose: sign of f = alpha*n_self + beta - n_other for each arm.
    for (genvar g = 0; g < NUM_ARMS; g++) begin : g_fn
        logic [FW-1:0] prod, fsum;
        assign prod = FW'(alpha[g]) * FW'(n_arm[g]);
        assign fsum = prod + {{(FW-BW){beta[g][BW-1]}}, beta[g]}
                           - FW'(n_arm[NUM_ARMS-1-g]);
        assign f_nonpos[g] = fsum[FW-1] || (fsum == '0);
    end

    assign min_sel    = gmin[arm_sel];
    assign max_sel    = gmax[arm_sel];
    assign self_empty = (n_arm[arm_sel] == '0);

    // Purpose: apply the per-phase minimum, maximum and early-exit rules.
    always_comb begin
        want = 1'b0;
        case (phase)
            PH_MAIN: begin
                if (t_val >= min_sel)
                    want = (t_val >= max_sel) || f_nonpos[arm_sel]
                           || self_empty || stalled;
            end
            PH_LEFT: begin
                if (t_val >= left_min)
                    want = (t_val >= left_max) || self_empty;
            end
            PH_PED:  want = (t_val >= ped_max);
            PH_HOLD: want = 1'b0;
        endcase
    end

    // Purpose: register the request; a pulse blocks the next cycle's one.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_req <= 1'b0;
        else        sw_req <= want && !sw_req;
    end

    assert_min_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && $past(phase) == PH_MAIN) |-> ($past(t_val) >= $past(min_sel)));
    assert_max_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_req && phase == PH_MAIN && t_val >= max_sel && t_val >= min_sel) |=> sw_req);
    assert_left_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_req && phase == PH_LEFT && t_val >= left_max && t_val >= left_min) |=> sw_req);
    assert_left_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && $past(phase) == PH_LEFT) |-> ($past(t_val) >= $past(left_min)));
    assert_ped_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_req && phase == PH_PED && t_val >= ped_max) |=> sw_req);
    assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD) |=> !sw_req);
    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req |=> !sw_req);
endmodule

// File: rtl/green_end_decider.sv
// Module: top of the adaptive green-time decision unit. Counts cars per arm,
// times the phase and raises a one-cycle request to end it.
// Assumes the sequencer changes phase/arm only after a request.
module green_end_decider
    import gtd_pkg::*;
#(
    parameter int CW          = 11,
    parameter int TW          = 8,
    parameter int AW          = 4,
    parameter int BW          = 12,
    parameter int STALL_TICKS = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [1:0]           car_enter,
    input  logic [1:0]           car_leave,
    input  logic                 arm_sel,
    input  logic [1:0]           phase,
    input  logic [AW-1:0]        alpha_a0,
    input  logic [AW-1:0]        alpha_a1,
    input  logic signed [BW-1:0] beta_a0,
    input  logic signed [BW-1:0] beta_a1,
    input  logic [TW-1:0]        gmin_a0,
    input  logic [TW-1:0]        gmax_a0,
    input  logic [TW-1:0]        gmin_a1,
    input  logic [TW-1:0]        gmax_a1,
    input  logic [TW-1:0]        left_min,
    input  logic [TW-1:0]        left_max,
    input  logic [TW-1:0]        ped_max,
    output logic                 switch_req
);
    logic [NUM_ARMS-1:0][CW-1:0] n_arm;
    logic [NUM_ARMS-1:0]         moved;
    logic [NUM_ARMS-1:0][AW-1:0] alpha_v;
    logic [NUM_ARMS-1:0][BW-1:0] beta_v;
    logic [NUM_ARMS-1:0][TW-1:0] gmin_v, gmax_v;
    logic [TW-1:0]               t_val;
    logic                        stalled;
    gtd_phase_e                  ph;

    assign ph      = gtd_phase_e'(phase);
    assign alpha_v = {alpha_a1, alpha_a0};
    assign beta_v  = {beta_a1, beta_a0};
    assign gmin_v  = {gmin_a1, gmin_a0};
    assign gmax_v  = {gmax_a1, gmax_a0};

    // Purpose: one queue counter per arm.
    for (genvar g = 0; g < NUM_ARMS; g++) begin : g_arm
        gtd_car_tally #(.CW(CW)) u_tally (
            .clk   (clk),
            .rst_n (rst_n),
            .enter (car_enter[g]),
            .leave (car_leave[g]),
            .cnt   (n_arm[g]),
            .moved (moved[g])
        );
    end

    gtd_phase_clock #(.TW(TW), .STALL_TICKS(STALL_TICKS)) u_clock (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .clear      (switch_req),
        .self_moved (moved[arm_sel]),
        .t_val      (t_val),
        .stalled    (stalled)
    );

    gtd_verdict #(.CW(CW), .TW(TW), .AW(AW), .BW(BW)) u_verdict (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (ph),
        .arm_sel  (arm_sel),
        .t_val    (t_val),
        .stalled  (stalled),
        .n_arm    (n_arm),
        .alpha    (alpha_v),
        .beta     (beta_v),
        .gmin     (gmin_v),
        .gmax     (gmax_v),
        .left_min (left_min),
        .left_max (left_max),
        .ped_max  (ped_max),
        .sw_req   (switch_req)
    );
endmodule

// File: tb/green_end_decider_tb_top.sv
// Bench: scoreboard of expected request cycles; a monitor pops and compares.
module green_end_decider_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [1:0]        car_enter = '0;
    logic [1:0]        car_leave = '0;
    logic              arm_sel = 1'b0;
    logic [1:0]        phase = 2'd3;
    logic [3:0]        alpha_a0 = 4'd1, alpha_a1 = 4'd1;
    logic signed [11:0] beta_a0 = '0, beta_a1 = '0;
    logic [7:0]        gmin_a0 = 8'd2, gmax_a0 = 8'd20, gmin_a1 = 8'd2, gmax_a1 = 8'd20;
    logic [7:0]        left_min = 8'd2, left_max = 8'd20, ped_max = 8'd20;
    logic              switch_req;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    green_end_decider dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .car_enter(car_enter), .car_leave(car_leave),
        .arm_sel(arm_sel), .phase(phase),
        .alpha_a0(alpha_a0), .alpha_a1(alpha_a1),
        .beta_a0(beta_a0), .beta_a1(beta_a1),
        .gmin_a0(gmin_a0), .gmax_a0(gmax_a0),
        .gmin_a1(gmin_a1), .gmax_a1(gmax_a1),
        .left_min(left_min), .left_max(left_max), .ped_max(ped_max),
        .switch_req(switch_req)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: every observed request must match the head of the scoreboard.
    always @(negedge clk) begin
        int    e;
        string t;
        if (rst_n && switch_req) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R11 unexpected request at cycle %0d, expected none", cyc);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e != cyc) begin
                    n_bad++;
                    $display("FAIL %s request at cycle %0d, expected cycle %0d", t, cyc, e);
                end
            end
        end
    end

    task automatic push_exp(int at, string tag);
        exp_q.push_back(at);
        tag_q.push_back(tag);
    endtask

    task automatic await_exp(int at, string tag);
        while (cyc < at) @(negedge clk);
        #1;
        if (exp_q.size() > 0 && exp_q[0] == at) begin
            n_chk++;
            n_bad++;
            $display("FAIL %s no request, actual none expected cycle %0d", tag, at);
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
    endtask

    task automatic restart();
        @(negedge clk); #1;
        rst_n = 1'b0; tick = 1'b0; car_enter = '0; car_leave = '0;
        phase = 2'd2; ped_max = 8'd0;   // would request at once without reset
        repeat (2) @(negedge clk);
        n_chk++;
        if (switch_req !== 1'b0) begin
            n_bad++;
            $display("FAIL R12 request during reset, actual %b expected 0", switch_req);
        end
        #1 phase = 2'd3;
        @(negedge clk); #1 rst_n = 1'b1;
    endtask

    task automatic load(int a, int n);
        repeat (n) begin @(negedge clk); #1 car_enter[a] = 1'b1; end
        @(negedge clk); #1 car_enter[a] = 1'b0;
    endtask

    task automatic drain(int a, int n);
        repeat (n) begin @(negedge clk); #1 car_leave[a] = 1'b1; end
        @(negedge clk); #1 car_leave[a] = 1'b0;
    endtask

    task automatic go(logic [1:0] ph, logic arm, output int cs);
        @(negedge clk); #1;
        phase = ph; arm_sel = arm; tick = 1'b1; cs = cyc;
    endtask

    task automatic settle();
        @(negedge clk); #1 phase = 2'd3; tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic main0(int mn, int mx, int al, int be);
        gmin_a0 = 8'(mn); gmax_a0 = 8'(mx); alpha_a0 = 4'(al); beta_a0 = 12'(be);
    endtask

    initial begin : watchdog
        #2000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired, actual hung expected finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : driver
        int cs;
        // R12: request held low under reset
        restart();

        // R5 + R11: max forces request, then re-armed from zero time
        main0(2, 4, 1, 100); load(0, 3); load(1, 1);
        go(2'd0, 1'b0, cs);
        push_exp(cs + 5, "R5"); push_exp(cs + 11, "R11");
        await_exp(cs + 5, "R5"); await_exp(cs + 11, "R11");
        settle();

        // R4 + R6: empty queue, but not before minimum
        restart(); main0(6, 20, 1, 0);
        go(2'd0, 1'b0, cs); push_exp(cs + 7, "R4"); await_exp(cs + 7, "R4"); settle();

        // R3: f = 2+2-5 = -1
        restart(); main0(3, 30, 1, 2); load(0, 2); load(1, 5);
        go(2'd0, 1'b0, cs); push_exp(cs + 4, "R3"); await_exp(cs + 4, "R3"); settle();

        // R3: f = 0 boundary
        restart(); main0(3, 30, 1, 2); load(0, 2); load(1, 4);
        go(2'd0, 1'b0, cs); push_exp(cs + 4, "R3"); await_exp(cs + 4, "R3"); settle();

        // R7: f = +1, ends by stall after five ticks
        restart(); main0(3, 30, 1, 2); load(0, 2); load(1, 3);
        go(2'd0, 1'b0, cs); push_exp(cs + 6, "R7"); await_exp(cs + 6, "R7"); settle();

        // R7: queue change after three ticks restarts the stall tally
        restart(); main0(3, 30, 1, 2); load(0, 2); load(1, 3);
        go(2'd0, 1'b0, cs); push_exp(cs + 10, "R7");
        while (cyc < cs + 3) @(negedge clk);
        #1 car_enter[0] = 1'b1;
        @(negedge clk); #1 car_enter[0] = 1'b0;
        await_exp(cs + 10, "R7"); settle();

        // R3: alpha weights the own queue, 3*3+1-9 = +1 -> stall exit
        restart(); main0(2, 30, 3, 1); load(0, 3); load(1, 9);
        go(2'd0, 1'b0, cs); push_exp(cs + 6, "R3"); await_exp(cs + 6, "R3"); settle();

        // R3: negative beta, 4-4-0 = 0
        restart(); main0(3, 30, 1, -4); load(0, 4);
        go(2'd0, 1'b0, cs); push_exp(cs + 4, "R3"); await_exp(cs + 4, "R3"); settle();

        // R4: arm 1 uses its own limits
        restart(); main0(10, 20, 1, 0);
        gmin_a1 = 8'd2; gmax_a1 = 8'd3; alpha_a1 = 4'd1; beta_a1 = 12'sd50;
        load(1, 4); load(0, 1);
        go(2'd0, 1'b1, cs); push_exp(cs + 4, "R4"); await_exp(cs + 4, "R4"); settle();

        // R8: left turn, queue present, no stall rule -> left maximum
        restart(); main0(2, 20, 1, 0); left_min = 8'd2; left_max = 8'd7; load(0, 3);
        go(2'd1, 1'b0, cs); push_exp(cs + 8, "R8"); await_exp(cs + 8, "R8"); settle();

        // R8: left turn, empty queue -> left minimum
        restart(); left_min = 8'd2; left_max = 8'd7;
        go(2'd1, 1'b0, cs); push_exp(cs + 3, "R8"); await_exp(cs + 3, "R8"); settle();

        // R9: pedestrian duration ignores empty queues
        restart(); main0(1, 20, 1, 0);
        go(2'd2, 1'b0, cs); ped_max = 8'd5;
        push_exp(cs + 6, "R9"); await_exp(cs + 6, "R9"); settle();

        // R10: hold never requests, even with everything expired
        restart(); main0(0, 0, 1, -100);
        go(2'd3, 1'b0, cs);
        repeat (30) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R10 scoreboard not empty, actual %0d expected 0", exp_q.size());
        end
        settle();

        // R2: leaves at zero are lost: 1, 0, 0, then 1 -> non-empty -> max
        restart(); main0(2, 4, 1, 100);
        load(0, 1); drain(0, 2); load(0, 1);
        go(2'd0, 1'b0, cs); push_exp(cs + 5, "R2"); await_exp(cs + 5, "R2"); settle();

        // R1: paired pulses do not change count nor restart the stall tally
        restart(); main0(2, 20, 1, 100); load(0, 2);
        go(2'd0, 1'b0, cs); push_exp(cs + 6, "R1");
        while (cyc < cs + 2) @(negedge clk);
        #1 begin car_enter[0] = 1'b1; car_leave[0] = 1'b1; end
        @(negedge clk); #1 begin car_enter[0] = 1'b0; car_leave[0] = 1'b0; end
        await_exp(cs + 6, "R1"); settle();

        // R2: 2049 entries stop at 2047; 2046 exits leave 1 -> max
        restart(); main0(2, 4, 1, 100);
        load(0, 2049); drain(0, 2046);
        go(2'd0, 1'b0, cs); push_exp(cs + 5, "R2"); await_exp(cs + 5, "R2"); settle();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule